// File: doc/BRIEF.md
# First-Come First-Served Request Arbiter

This block shares one resource among four requesters and hands it out in the order the requests arrived. No requester outranks another by index. Requests and grants are active-low lines, and a single active-low output enable can hold every grant off. Each request line is first brought into the clock domain through a chain of flip-flops. A synchronized falling edge then counts as an arrival, and the requester's index is appended to an ordered waiting list. The entry at the front of that list owns the grant.

When the owner lets go of its request line, its entry leaves the list and the next entry in arrival order takes over. The old grant drops and the new one rises on the same clock edge. A requester that gives up before it is served is taken out of the list, and everyone behind it moves up without changing their relative order. If several requesters arrive on the same cycle while nobody is waiting, they are listed in ascending index order. All grants then stay inactive for one extra cycle before the winner is driven, so a grant can never flicker onto the wrong line. The output enable only masks the grant outputs. The list keeps tracking requests while the enable is off, so the right owner appears as soon as the enable comes back.

Top module: `fcfs_arbiter`

## Requirements
- R1: Grant line n (bit n of `gnt_n`) belongs to request line n (bit n of `req_n`), and both are active low (0 = asserted). A request change becomes visible at the grants on the fourth rising edge after it is applied: two synchronizer stages, one list update and one output register.
- R2: When nobody is waiting, the first request to arrive is granted, whatever its index.
- R3: A request that arrives while another is being served waits. When the owner releases, the grant goes to the oldest waiting request, in arrival order and not in index order.
- R4: While `oe_n` is 1, every grant output is 1 from the next rising edge onward, whatever the requests are.
- R5: `oe_n` only masks the outputs. The arrival list keeps updating while it is 1, and one rising edge after `oe_n` returns to 0 the grant shows the current oldest request.
- R6: When two or more requests arrive on the same cycle and the list holds nothing else, all grants stay 1 for one extra cycle. The lowest-indexed of them is then granted, and the others follow in ascending index order.
- R7: A waiting request that is released before it is served is removed from the list. The requests behind it keep their order.
- R8: At most one grant is 0 at any time. On a handover the old grant rises and the new grant falls on the same edge.
- R9: Holding `rst_n` at 0 across a rising edge empties the list and drives every grant to 1 from that edge. After release, requests that are already held count as new arrivals.
- R10: A request line held at 1 is never granted and does not change the order in which the other requesters are served.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| oe_n | input | 1 | Grant output enable, active low |
| req_n | input | 4 | Request lines, active low, one per requester |
| gnt_n | output | 4 | Grant lines, active low, one per requester |

## Verification
Several request patterns are applied. A lone request shows the basic latency and the pin mapping. A chain of arrivals in an order different from their indices shows that service follows arrival and not index. A pair arriving on the same cycle into an empty list exposes the one-cycle blank and the ascending tie order. Releasing a waiting request in the middle of the chain shows that it is removed cleanly without disturbing the others. Switching the enable off while requests change shows that it masks the outputs without freezing the list. A reset applied mid-service, with a request still held low, shows that the list empties and that the held request is re-admitted as a fresh arrival.

// File: rtl/fcfs_pkg.sv
// Shared definitions for the first-come first-served arbiter.
// Assumes: nothing beyond IEEE 1800-2017.
package fcfs_pkg;

    // Reason the grant output takes its next value.
    typedef enum logic [1:0] {
        GNT_IDLE   = 2'd0,  // nothing waiting
        GNT_SETTLE = 2'd1,  // same-cycle arrivals being settled
        GNT_MASKED = 2'd2,  // output enable off
        GNT_DRIVE  = 2'd3   // front of the list drives its grant
    } gnt_mode_e;

endpackage

// File: rtl/fcfs_req_sync.sv
// Brings the asynchronous active-low requests into the clock domain.
// Output is active high. Assumes: STAGES >= 2, reset is synchronous.
module fcfs_req_sync #(
    parameter int N_REQ  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] req_n,
    output logic [N_REQ-1:0] req_act
);

    logic [N_REQ-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // Purpose: first capture of the inverted request lines.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= ~req_n;
            end
        end else begin : g_next
            // Purpose: further settling stages of the synchronizer.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign req_act = stage_q[STAGES-1];

endmodule

// File: rtl/fcfs_order_queue.sv
// Keeps requester indices in arrival order. Each cycle it drops every entry
// whose request has gone away, closes the gaps, and then appends the new
// arrivals in ascending index order. It raises a one-cycle settle flag when
// several requesters arrive together into an empty list.
// Assumes: req_act is already synchronized.
module fcfs_order_queue #(
    parameter int N_REQ = 4,
    localparam int IDXW = (N_REQ > 1) ? $clog2(N_REQ) : 1,
    localparam int CNTW = $clog2(N_REQ + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] req_act,
    output logic [IDXW-1:0]  head_idx,
    output logic             head_valid,
    output logic             settle
);

    logic [IDXW-1:0]  slot_q [N_REQ];
    logic [IDXW-1:0]  slot_d [N_REQ];
    logic [CNTW-1:0]  cnt_q, cnt_d;
    logic [N_REQ-1:0] prev_q;
    logic [N_REQ-1:0] arrive;
    logic             settle_q, settle_d;

    // Purpose: compact the surviving entries, then append the new arrivals.
    always_comb begin
        int k;
        int kept;
        arrive = req_act & ~prev_q;
        slot_d = slot_q;
        k = 0;
        for (int i = 0; i < N_REQ; i++) begin
            if (i < int'(cnt_q) && req_act[slot_q[i]]) begin
                slot_d[k[IDXW-1:0]] = slot_q[i];
                k = k + 1;
            end
        end
        kept = k;
        for (int j = 0; j < N_REQ; j++) begin
            if (arrive[j] && k < N_REQ) begin
                slot_d[k[IDXW-1:0]] = IDXW'(j);
                k = k + 1;
            end
        end
        cnt_d    = CNTW'(k);
        settle_d = (kept == 0) && ($countones(arrive) > 1);
    end

    // Purpose: register the list, its fill and the previous request state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_REQ; i++) slot_q[i] <= '0;
            cnt_q    <= '0;
            prev_q   <= '0;
            settle_q <= 1'b0;
        end else begin
            slot_q   <= slot_d;
            cnt_q    <= cnt_d;
            prev_q   <= req_act;
            settle_q <= settle_d;
        end
    end

    assign head_idx   = slot_q[0];
    assign head_valid = (cnt_q != '0);
    assign settle     = settle_q;

endmodule

// File: rtl/fcfs_grant_drive.sv
// Turns the front of the arrival list into registered active-low grants.
// Grants are blanked while the list is empty, while a tie is settling, or
// while the output enable is off. Assumes: head_idx < N_REQ when valid.
module fcfs_grant_drive
    import fcfs_pkg::*;
#(
    parameter int N_REQ = 4,
    localparam int IDXW = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             oe_n,
    input  logic [IDXW-1:0]  head_idx,
    input  logic             head_valid,
    input  logic             settle,
    output logic [N_REQ-1:0] gnt_n
);

    gnt_mode_e        mode;
    logic [N_REQ-1:0] gnt_d, gnt_q;

    // Purpose: choose why the grants take their next value.
    always_comb begin
        if (!head_valid)  mode = GNT_IDLE;
        else if (settle)  mode = GNT_SETTLE;
        else if (oe_n)    mode = GNT_MASKED;
        else              mode = GNT_DRIVE;
    end

    // Purpose: decode the front index into one active-low grant.
    always_comb begin
        gnt_d = '1;
        if (mode == GNT_DRIVE) gnt_d[head_idx] = 1'b0;
    end

    // Purpose: register the grants so they cannot glitch.
    always_ff @(posedge clk) begin
        if (!rst_n) gnt_q <= '1;
        else        gnt_q <= gnt_d;
    end

    assign gnt_n = gnt_q;

endmodule

// File: rtl/fcfs_arbiter.sv
// Top level of the first-come first-served arbiter: synchronizer, arrival
// list and grant driver in a chain. Assumes: one clock, synchronous
// active-low reset, asynchronous active-low request lines.
module fcfs_arbiter #(
    parameter int N_REQ       = 4,
    parameter int SYNC_STAGES = 2,
    localparam int IDXW = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             oe_n,
    input  logic [N_REQ-1:0] req_n,
    output logic [N_REQ-1:0] gnt_n
);

    logic [N_REQ-1:0] req_act;
    logic [IDXW-1:0]  head_idx;
    logic             head_valid;
    logic             settle;

    fcfs_req_sync #(.N_REQ(N_REQ), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_n   (req_n),
        .req_act (req_act)
    );

    fcfs_order_queue #(.N_REQ(N_REQ)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_act    (req_act),
        .head_idx   (head_idx),
        .head_valid (head_valid),
        .settle     (settle)
    );

    fcfs_grant_drive #(.N_REQ(N_REQ)) u_drive (
        .clk        (clk),
        .rst_n      (rst_n),
        .oe_n       (oe_n),
        .head_idx   (head_idx),
        .head_valid (head_valid),
        .settle     (settle),
        .gnt_n      (gnt_n)
    );

endmodule

// File: rtl/fcfs_arbiter_chk.sv
// Property checker for fcfs_arbiter, attached with bind below.
// Assumes: the names settle and head_valid exist inside the top module.
module fcfs_arbiter_chk #(
    parameter int N_REQ = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             oe_n,
    input logic [N_REQ-1:0] gnt_n,
    input logic             settle,
    input logic             head_valid
);

    // At most one grant active at any time.
    assert_one_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~gnt_n) <= 1);

    // Enable off blanks every grant from the next edge.
    assert_oe_blanks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |=> (gnt_n == '1));

    // Reset drives all grants inactive from the next edge.
    assert_reset_idle_R9: assert property (@(posedge clk)
        !rst_n |=> (gnt_n == '1));

    // While a tie is settling, no grant may appear.
    assert_tie_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
        settle |=> (gnt_n == '1));

    // A grant implies the list held an owner on the previous edge.
    assert_grant_has_owner_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_n != '1) |-> $past(head_valid));

endmodule

bind fcfs_arbiter fcfs_arbiter_chk #(.N_REQ(N_REQ)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .oe_n       (oe_n),
    .gnt_n      (gnt_n),
    .settle     (settle),
    .head_valid (head_valid)
);

// File: tb/fcfs_arbiter_bench.sv
// Scoreboard bench: the driver queues expected grant values with the cycle
// they are due, and a monitor compares them against gnt_n on falling edges.
module fcfs_arbiter_bench;

    typedef struct {
        int         due;
        logic [3:0] exp;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       oe_n = 1'b0;
    logic [3:0] req_n = 4'b1111;
    logic [3:0] gnt_n;

    int    cyc = 0;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    item_t sb[$];

    fcfs_arbiter u_fcfs_arbiter (
        .clk   (clk),
        .rst_n (rst_n),
        .oe_n  (oe_n),
        .req_n (req_n),
        .gnt_n (gnt_n)
    );

    // 50 MHz clock.
    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pop and compare every item due this cycle.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            item_t it;
            it = sb.pop_front();
            n_cmp++;
            if (it.due != cyc || gnt_n !== it.exp) begin
                n_bad++;
                $display("FAIL %s: cycle %0d gnt_n=%b expected %b",
                         it.tag, cyc, gnt_n, it.exp);
            end
        end
    end

    task automatic drive(input logic [3:0] r, input logic oe);
        @(negedge clk);
        req_n = r;
        oe_n  = oe;
    endtask

    task automatic expect_at(input int off, input logic [3:0] e, input string tag);
        item_t it;
        it.due = cyc + off;
        it.exp = e;
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // Reset state (R9)
        idle(3);
        expect_at(0, 4'b1111, "R9 reset idle");
        idle(1);
        @(negedge clk) rst_n = 1'b1;

        // Lone request 1 (R1, R2)
        drive(4'b1101, 1'b0);
        expect_at(3, 4'b1111, "R1 latency not yet");
        expect_at(4, 4'b1101, "R2 first arrival granted");
        idle(5);

        // Arrival order 1, 3, 0 (R3, R8, R10)
        drive(4'b0101, 1'b0);
        expect_at(4, 4'b1101, "R3 holder kept");
        idle(5);
        drive(4'b0100, 1'b0);
        expect_at(4, 4'b1101, "R3 holder kept again");
        idle(5);
        drive(4'b0110, 1'b0);
        expect_at(3, 4'b1101, "R8 old grant until handover");
        expect_at(4, 4'b0111, "R3 oldest waiter (3) before 0");
        idle(5);
        drive(4'b1110, 1'b0);
        expect_at(4, 4'b1110, "R3 next waiter 0");
        idle(5);
        drive(4'b1111, 1'b0);
        expect_at(4, 4'b1111, "R10 requester 2 never granted");
        idle(5);

        // Enable masking (R4, R5)
        drive(4'b1011, 1'b0);
        expect_at(4, 4'b1011, "R1 grant 2");
        idle(5);
        drive(4'b1011, 1'b1);
        expect_at(1, 4'b1111, "R4 enable off blanks");
        idle(3);
        drive(4'b1111, 1'b1);
        idle(5);
        drive(4'b0111, 1'b1);
        expect_at(4, 4'b1111, "R4 still blanked");
        idle(5);
        drive(4'b0111, 1'b0);
        expect_at(1, 4'b0111, "R5 list tracked while masked");
        idle(3);
        drive(4'b1111, 1'b0);
        expect_at(4, 4'b1111, "R5 release");
        idle(5);

        // Simultaneous arrivals 0 and 2 (R6)
        drive(4'b1010, 1'b0);
        expect_at(3, 4'b1111, "R6 before arrival");
        expect_at(4, 4'b1111, "R6 settle blank");
        expect_at(5, 4'b1110, "R6 lowest index first");
        idle(6);
        drive(4'b1011, 1'b0);
        expect_at(4, 4'b1011, "R6 next ascending");
        idle(5);
        drive(4'b1111, 1'b0);
        expect_at(4, 4'b1111, "R6 drained");
        idle(5);

        // Withdrawal of a waiter (R7, R10)
        drive(4'b1101, 1'b0);
        expect_at(4, 4'b1101, "R7 owner 1");
        idle(5);
        drive(4'b1001, 1'b0);
        idle(5);
        drive(4'b0001, 1'b0);
        idle(5);
        drive(4'b0101, 1'b0);
        expect_at(4, 4'b1101, "R7 owner unaffected by withdrawal");
        idle(5);
        drive(4'b0111, 1'b0);
        expect_at(4, 4'b0111, "R7 skips withdrawn 2");
        idle(5);
        drive(4'b1111, 1'b0);
        expect_at(4, 4'b1111, "R10 idle line 0 never granted");
        idle(5);

        // Reset mid-service (R9)
        drive(4'b1110, 1'b0);
        expect_at(4, 4'b1110, "R1 grant 0");
        idle(5);
        @(negedge clk) rst_n = 1'b0;
        expect_at(1, 4'b1111, "R9 reset clears grant");
        idle(3);
        @(negedge clk) rst_n = 1'b1;
        expect_at(3, 4'b1111, "R9 still refilling");
        expect_at(4, 4'b1110, "R9 held request re-arrives");
        idle(6);

        done = 1'b1;
    end

    // Watchdog and final report.
    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog: run hung, got timeout expected done");
            end
        join_any
        idle(2);
        if (sb.size() != 0) begin
            n_cmp++;
            n_bad++;
            $display("FAIL scoreboard: %0d items left expected 0", sb.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule